// File: doc/BRIEF.md
# Line-Synchronized Pre-Charge Pulse Sequencer

This block drives the enable of an input power switch so that a bulk capacitor fills up in a series of short conduction pulses. Each pulse is tied to the rectified mains waveform. Every line cycle uses one entry of an internal table. The entry supplies an off-time, which places the pulse, and an on-time, which sets how long the pulse lasts.

A pulse starts from the line comparator's rising-edge event. A first one-shot counts a delay equal to the line period minus the entry's off-time, minus the measured zero-cross time, minus a trim value. This places the pulse on the falling slope of the half-sine. When the delay runs out, the enable goes high and a second one-shot counts the on-time. When that one runs out, the enable goes low.

After the last entry has been used, the block raises its completion flag and holds the enable high, so the switch keeps conducting. A start input arms the sequence. A synchronous abort input drops the enable and returns the block to idle.

Top module: `precharge_seq`

## Requirements
- R1: While reset is held, and on the first cycle after release, the gate enable and the done flag are low and the table address is 0.
- R2: When `line_rise` is sampled high while armed for entry i, the gate enable rises exactly D clock edges later. D = `line_period` − off(i) − `zc_time` − `zc_trim`, taken from the inputs sampled with the event. The table holds off(i) = (OFF_BASE + i·OFF_STEP) mod 2^TW.
- R3: If that difference is zero or negative, D saturates to 1 cycle.
- R4: The gate enable then stays high for exactly W edges and falls, where W = (ON_BASE + i·ON_STEP) mod 2^TW, raised to 1 if that value is 0. This applies to every entry except the last.
- R5: `line_rise` has no effect while the block is idle or while a pulse is in progress (during the delay or the on-phase).
- R6: `rom_addr` shows the entry in use. It advances by exactly one, at the edge where a non-last pulse's on-phase ends, and at no other time.
- R7: When the on-phase of entry DEPTH−1 ends, `done` rises and the gate enable stays high continuously. `rom_addr` stays at DEPTH−1, and further line events change nothing.
- R8: An `abort` sampled high forces the gate enable low, `done` low, `rom_addr` to 0 and the block to idle at that same edge, from any state. Abort takes priority over start.
- R9: `start` arms the block at entry 0 only from idle. In any other state it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the sequence from idle |
| abort | input | 1 | Synchronous return to idle, gate off |
| line_rise | input | 1 | One-cycle line comparator rising-edge event |
| line_period | input | TW | Line period in clock ticks |
| zc_time | input | TW | Zero-cross time in ticks |
| zc_trim | input | TW | Zero-cross compensation in ticks |
| gate_en | output | 1 | Switch gate enable |
| done | output | 1 | Pre-charge train finished |
| rom_addr | output | AW | Table entry in use |

## Verification
The bench builds the block with TW = 12 and a table depth of 6 instead of 255. With these values a complete train, the done/hold state and a restart after abort all fit in a few thousand cycles. The offsets start at 40 and grow by 8 per entry, so a short line period reaches delay saturation. The on-times start at 5 and grow by 3 per entry, so every pulse has a distinct width to measure. Line period, zero-cross time and trim are drawn at random for each pulse from a fixed seed. Directed cases cover underflow, events during a pulse, abort mid-delay and abort colliding with start.

// File: rtl/precharge_pkg.sv
package precharge_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ARMED = 3'd1,
    SQ_DELAY = 3'd2,
    SQ_ON    = 3'd3,
    SQ_HOLD  = 3'd4
  } seq_state_t;

  // Delay before a pulse: period minus the three subtrahends, floored at one tick.
  function automatic int sat_delay(int period, int off_t, int zc, int trim);
    int d;
    d = period - off_t - zc - trim;
    return (d < 1) ? 1 : d;
  endfunction

  // Pulse width: a zero entry still yields a one-tick pulse.
  function automatic int sat_width(int w);
    return (w < 1) ? 1 : w;
  endfunction

  // Table entry value base + idx*step, wrapped to tw bits.
  function automatic int table_val(int base, int step, int idx, int tw);
    longint v;
    v = longint'(base) + longint'(idx) * longint'(step);
    return int'(v & ((longint'(1) <<< tw) - 1));
  endfunction

endpackage

// File: rtl/pulse_rom.sv
module pulse_rom
  import precharge_pkg::*;
#(
  parameter int TW        = 16,
  parameter int DEPTH     = 255,
  parameter int AW        = 8,
  parameter int OFF_BASE  = 400,
  parameter int OFF_STEP  = 20,
  parameter int ON_BASE   = 30,
  parameter int ON_STEP   = 2
) (
  input  logic [AW-1:0] addr,
  output logic [TW-1:0] off_val,
  output logic [TW-1:0] on_val
);

  logic [TW-1:0] off_tab [DEPTH];
  logic [TW-1:0] on_tab  [DEPTH];

  // Contents are computed per entry rather than written out.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int OFFV = table_val(OFF_BASE, OFF_STEP, i, TW);
    localparam int ONV  = table_val(ON_BASE, ON_STEP, i, TW);
    assign off_tab[i] = TW'(OFFV);
    assign on_tab[i]  = TW'(ONV);
  end

  always_comb begin
    if (int'(addr) < DEPTH) begin
      off_val = off_tab[addr];
      on_val  = on_tab[addr];
    end else begin
      off_val = '0;
      on_val  = '0;
    end
  end

endmodule

// File: rtl/delay_calc.sv
module delay_calc
  import precharge_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [TW-1:0] line_period,
  input  logic [TW-1:0] off_val,
  input  logic [TW-1:0] zc_time,
  input  logic [TW-1:0] zc_trim,
  input  logic [TW-1:0] on_val,
  output logic [TW-1:0] delay_ticks,
  output logic [TW-1:0] width_ticks
);

  assign delay_ticks = TW'(sat_delay(int'(line_period), int'(off_val),
                                     int'(zc_time), int'(zc_trim)));
  assign width_ticks = TW'(sat_width(int'(on_val)));

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire,
  output logic          running
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign running = (cnt != '0);
  assign expire  = (cnt == TW'(1));

  // R3: a one-shot is never started with a zero count
  a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

  // R2: once expired, the counter is idle until reloaded
  a_r2_expire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && !clr) |=> !running);

endmodule

// File: rtl/precharge_seq.sv
module precharge_seq
  import precharge_pkg::*;
#(
  parameter int TW        = 16,
  parameter int DEPTH     = 255,
  parameter int OFF_BASE  = 400,
  parameter int OFF_STEP  = 20,
  parameter int ON_BASE   = 30,
  parameter int ON_STEP   = 2,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          line_rise,
  input  logic [TW-1:0] line_period,
  input  logic [TW-1:0] zc_time,
  input  logic [TW-1:0] zc_trim,
  output logic          gate_en,
  output logic          done,
  output logic [AW-1:0] rom_addr
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  seq_state_t    st;
  logic [TW-1:0] off_val, on_val, delay_ticks, width_ticks;
  logic          dly_load, dly_exp, dly_run;
  logic          on_load, on_exp, on_run;
  logic          last_entry;

  pulse_rom #(
    .TW(TW), .DEPTH(DEPTH), .AW(AW),
    .OFF_BASE(OFF_BASE), .OFF_STEP(OFF_STEP),
    .ON_BASE(ON_BASE), .ON_STEP(ON_STEP)
  ) u_rom (
    .addr(rom_addr), .off_val(off_val), .on_val(on_val)
  );

  delay_calc #(.TW(TW)) u_calc (
    .line_period(line_period), .off_val(off_val), .zc_time(zc_time),
    .zc_trim(zc_trim), .on_val(on_val),
    .delay_ticks(delay_ticks), .width_ticks(width_ticks)
  );

  // Named events shared by the FSM and the assertions
  assign last_entry = (rom_addr == LAST_ADDR);
  assign dly_load   = (st == SQ_ARMED) && line_rise && !abort;
  assign on_load    = (st == SQ_DELAY) && dly_exp && !abort;

  pulse_oneshot #(.TW(TW)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(abort), .load(dly_load),
    .load_val(delay_ticks), .expire(dly_exp), .running(dly_run)
  );

  pulse_oneshot #(.TW(TW)) u_width (
    .clk(clk), .rst_n(rst_n), .clr(abort), .load(on_load),
    .load_val(width_ticks), .expire(on_exp), .running(on_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      rom_addr <= '0;
      gate_en  <= 1'b0;
      done     <= 1'b0;
    end else if (abort) begin
      st       <= SQ_IDLE;
      rom_addr <= '0;
      gate_en  <= 1'b0;
      done     <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            st       <= SQ_ARMED;
            rom_addr <= '0;
          end
        end
        SQ_ARMED: begin
          if (line_rise) st <= SQ_DELAY;
        end
        SQ_DELAY: begin
          if (dly_exp) begin
            st      <= SQ_ON;
            gate_en <= 1'b1;
          end
        end
        SQ_ON: begin
          if (on_exp) begin
            if (last_entry) begin
              st   <= SQ_HOLD;
              done <= 1'b1;
            end else begin
              st       <= SQ_ARMED;
              rom_addr <= rom_addr + 1'b1;
              gate_en  <= 1'b0;
            end
          end
        end
        SQ_HOLD: ;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R2: gate rises on the edge the delay one-shot expires
  a_r2_gate_on_delay_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DELAY && dly_exp && !abort) |=> gate_en);

  // R4: gate falls when a non-last width one-shot expires
  a_r4_gate_off_after_width: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ON && on_exp && !last_entry && !abort) |=> !gate_en);

  // R4: gate stays high while the width one-shot runs
  a_r4_gate_high_in_width: assert property (@(posedge clk) disable iff (!rst_n)
    on_run |-> gate_en);

  // R7: completion implies the switch is held on
  a_r7_done_holds_gate: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gate_en);

  // R8: abort clears outputs at the next edge
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!gate_en && !done && rom_addr == '0));

  // R6: address only steps by one or returns to zero
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr != $past(rom_addr)) |->
      (rom_addr == $past(rom_addr) + 1'b1 || rom_addr == '0));

  // R5: the two one-shots never run together
  a_r5_timers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_run && on_run));

endmodule

// File: tb/tb_precharge_seq.sv
module tb_precharge_seq;

  localparam int TW       = 12;
  localparam int DEPTH    = 6;
  localparam int OFF_BASE = 40;
  localparam int OFF_STEP = 8;
  localparam int ON_BASE  = 5;
  localparam int ON_STEP  = 3;
  localparam int AW       = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, abort = 1'b0, line_rise = 1'b0;
  logic [TW-1:0] line_period = '0, zc_time = '0, zc_trim = '0;
  logic          gate_en, done;
  logic [AW-1:0] rom_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  precharge_seq #(
    .TW(TW), .DEPTH(DEPTH), .OFF_BASE(OFF_BASE), .OFF_STEP(OFF_STEP),
    .ON_BASE(ON_BASE), .ON_STEP(ON_STEP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .line_rise(line_rise), .line_period(line_period), .zc_time(zc_time),
    .zc_trim(zc_trim), .gate_en(gate_en), .done(done), .rom_addr(rom_addr)
  );

  function automatic int exp_off(int i);
    return (OFF_BASE + i * OFF_STEP) % (1 << TW);
  endfunction

  function automatic int exp_width(int i);
    int w;
    w = (ON_BASE + i * ON_STEP) % (1 << TW);
    if (w == 0) w = 1;
    return w;
  endfunction

  function automatic int exp_delay(int p, int i, int z, int c);
    int d;
    d = p - exp_off(i) - z - c;
    if (d <= 0) d = 1;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
  endtask

  // One line cycle for entry idx. Optionally fires a spurious event in the on-phase.
  task automatic run_pulse(input int idx, input int p, input int z, input int c,
                           input bit inject);
    int expd, expw, n, w;
    expd = exp_delay(p, idx, z, c);
    expw = exp_width(idx);
    @(negedge clk);
    line_period = TW'(p); zc_time = TW'(z); zc_trim = TW'(c);
    check(int'(rom_addr) == idx, "R6 addr before pulse", int'(rom_addr), idx);
    line_rise = 1'b1;
    @(negedge clk) line_rise = 1'b0;
    n = 0;
    while (!gate_en && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (p - exp_off(idx) - z - c <= 0)
      check(n == expd, "R3 saturated delay", n, expd);
    else
      check(n == expd, "R2 delay", n, expd);
    if (idx == DEPTH - 1) begin
      for (int k = 0; k < expw + 3; k++) begin
        @(negedge clk);
        if (!gate_en) check(1'b0, "R7 gate held", 0, 1);
      end
      check(done == 1'b1, "R7 done raised", int'(done), 1);
      check(int'(rom_addr) == idx, "R7 addr held", int'(rom_addr), idx);
    end else begin
      w = 0;
      while (gate_en && w < 5000) begin
        line_rise = (inject && w == 0);
        @(negedge clk);
        w++;
      end
      line_rise = 1'b0;
      check(w == expw, "R4 width", w, expw);
      check(int'(rom_addr) == idx + 1, "R6 addr advanced", int'(rom_addr), idx + 1);
      check(done == 1'b0, "R7 done early", int'(done), 0);
      if (inject) begin
        n = 0;
        repeat (30) begin
          @(negedge clk);
          if (gate_en) n++;
        end
        check(n == 0, "R5 event in pulse ignored", n, 0);
      end
    end
  endtask

  task automatic run_train(input int underflow_at, input int inject_at, input int start_probe);
    int p, z, c;
    for (int i = 0; i < DEPTH; i++) begin
      p = 150 + int'($urandom % 100);
      z = 5 + int'($urandom % 16);
      c = int'($urandom % 11);
      if (i == underflow_at) p = 20 + int'($urandom % 30);
      run_pulse(i, p, z, c, i == inject_at);
      if (i == start_probe) begin
        pulse_start();
        check(int'(rom_addr) == i + 1, "R9 start ignored when armed", int'(rom_addr), i + 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int hi;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!gate_en && !done && rom_addr == '0, "R1 reset state", int'(gate_en), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!gate_en && !done && rom_addr == '0, "R1 after release", int'(rom_addr), 0);

    // R5: line events while idle do nothing
    line_period = TW'(200); zc_time = '0; zc_trim = '0;
    line_rise = 1'b1;
    @(negedge clk) line_rise = 1'b0;
    hi = 0;
    repeat (200) begin @(negedge clk); if (gate_en) hi++; end
    check(hi == 0, "R5 idle event ignored", hi, 0);

    // R8: abort wins over start
    @(negedge clk) begin start = 1'b1; abort = 1'b1; end
    @(negedge clk) begin start = 1'b0; abort = 1'b0; end
    line_rise = 1'b1;
    @(negedge clk) line_rise = 1'b0;
    hi = 0;
    repeat (200) begin @(negedge clk); if (gate_en) hi++; end
    check(hi == 0, "R8 abort beats start", hi, 0);

    // Full train with an underflow, a spurious event, and a start probe
    pulse_start();
    run_train(2, 3, 0);

    // R7: events after completion change nothing
    line_rise = 1'b1;
    @(negedge clk) line_rise = 1'b0;
    hi = 0;
    repeat (300) begin @(negedge clk); if (!gate_en || !done) hi++; end
    check(hi == 0, "R7 hold after done", hi, 0);
    check(int'(rom_addr) == DEPTH - 1, "R7 addr at end", int'(rom_addr), DEPTH - 1);
    pulse_start();
    check(done && int'(rom_addr) == DEPTH - 1, "R9 start ignored in hold", int'(rom_addr), DEPTH - 1);

    // R8: abort from the hold state
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    check(!gate_en && !done && rom_addr == '0, "R8 abort from hold", int'(gate_en), 0);

    // R8: abort during the delay of entry 2
    pulse_start();
    run_pulse(0, 180, 10, 3, 1'b0);
    run_pulse(1, 200, 8, 2, 1'b0);
    @(negedge clk) begin line_period = TW'(240); line_rise = 1'b1; end
    @(negedge clk) line_rise = 1'b0;
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    check(!gate_en && !done && rom_addr == '0, "R8 abort mid delay", int'(rom_addr), 0);
    hi = 0;
    repeat (300) begin @(negedge clk); if (gate_en) hi++; end
    check(hi == 0, "R8 stays idle after abort", hi, 0);

    // Second full random train from a fresh start
    pulse_start();
    run_train(DEPTH - 1, 1, -1);

    // R3: all subtrahends exceed the period
    pulse_abort();
    pulse_start();
    run_pulse(0, 10, 30, 20, 1'b0);

    finish_run();
  end

endmodule